// File: doc/BRIEF.md
# I2C Target Controller with Start/Stop Interrupt Flags

This block is a synchronous target (slave) for a two-wire open-drain serial bus. A fast system clock oversamples the clock and data lines, which pass through two-flop synchronizers and edge detectors. The block recognises start, repeated-start and stop conditions, keeps a bus-busy flag, compares the first byte after every start with a programmable 7-bit own address, and takes the direction bit from that byte's least significant position. It then receives or transmits data bytes with acknowledge handling. When the local side cannot take or supply a byte, it holds the clock line low until it can.

A host reaches the block through a small register port with an address, write and read strobes and combinational read data. Detection of start and stop sets raw flags that are cleared by writing one. A mask gates them into a masked view and a single interrupt line. The pads are modelled as output-enables: when an enable is high, the block pulls that line low.

Top module: `i2c_target`

## Requirements
- R1: After reset the block drives neither line (`scl_oe` = 0, `sda_oe` = 0), `irq` is 0, and status register 1 reads 0.
- R2: A fall of data while the clock is high (start) sets raw status bit 0 and busy bit 2 of register 1. A rise of data while the clock is high (stop) sets raw bit 1 and clears busy.
- R3: Writing register 1 clears each raw bit whose write-data bit is 1 and leaves a raw bit whose write-data bit is 0 unchanged.
- R4: Register 2 bits [1:0] are the mask. Register 3 reads raw AND mask. `irq` is high exactly when some masked bit is set.
- R5: The first byte after a start is taken MSB first: a 7-bit address, then a direction bit (0 = controller writes, 1 = controller reads). The own address is register 0 bits [6:0]. On a match the target pulls data low for the ninth clock. On a mismatch it drives neither line until the next start or stop.
- R6: In write direction, each later byte is assembled MSB first, acknowledged in its ninth clock, and returned by a read of register 5. That read clears the receive-full flag, which is bit 0 of register 6.
- R7: If a write byte completes while the previous byte is still unread, the target holds the clock low after the eighth bit until register 5 is read. It then acknowledges and stores the new byte.
- R8: In read direction, a byte written to register 4 (transmit-full is register 6 bit 1) is shifted out MSB first. Data changes only while the clock is low. If no byte is waiting when one is due, the target holds the clock low until register 4 is written.
- R9: In read direction, a not-acknowledge from the controller in the ninth clock ends the transfer. The target then leaves data released, so further clocking reads all ones, until the next start.
- R10: A repeated start (a start with no stop before it) restarts address matching while busy stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| scl_oe | output | 1 | High pulls the bus clock line low (stretch) |
| sda_oe | output | 1 | High pulls the bus data line low |
| reg_addr | input | AW (3) | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | DW (8) | Register write data |
| reg_rdata | output | DW (8) | Register read data, combinational |
| irq | output | 1 | OR of the masked start/stop flags |

## Verification
On every cycle, the assertions check how the busy flag and the raw flags follow each detected condition, how write-one-to-clear acts, and that a mask of zero keeps the interrupt quiet. They also check that a non-addressed target drives nothing, that every wait state holds the clock low, that data is never pulled low during a clock-high phase, and that a repeated start returns to address matching. Only the bench's scenarios can show the byte values themselves: the address acknowledge or its absence, MSB-first assembly and shifting, the length of each clock stretch, and the all-ones bytes after a not-acknowledge. Each of these needs a full bus transaction and a host model acting concurrently with it.

// File: rtl/i2c_target.sv
module i2c_target #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [AW-1:0] A_OWN  = AW'(0);
  localparam logic [AW-1:0] A_RAW  = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_MSK  = AW'(3);
  localparam logic [AW-1:0] A_TX   = AW'(4);
  localparam logic [AW-1:0] A_RX   = AW'(5);
  localparam logic [AW-1:0] A_FLG  = AW'(6);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK, S_WR, S_WAIT_RX, S_RD, S_WAIT_TX, S_RACK
  } st_t;

  st_t           state;
  logic [1:0]    scl_sync, sda_sync;
  logic          scl_q, sda_q;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg, rx_data, tx_data;
  logic [DW-2:0] own_addr;
  logic [1:0]    raw, mask;
  logic          dir, mack, busy, rx_full, tx_full;

  wire scl_s     = scl_sync[1];
  wire sda_s     = sda_sync[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire tx_wr     = reg_we && reg_addr == A_TX;
  wire rx_rd     = reg_re && reg_addr == A_RX;
  wire stat_wr   = reg_we && reg_addr == A_RAW;

  assign irq = |(raw & mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      own_addr <= '0;
      mask     <= '0;
      raw      <= '0;
    end else begin
      if (reg_we && reg_addr == A_OWN)  own_addr <= reg_wdata[DW-2:0];
      if (reg_we && reg_addr == A_MASK) mask <= reg_wdata[1:0];
      raw[0] <= start_det | (raw[0] & ~(stat_wr & reg_wdata[0]));
      raw[1] <= stop_det  | (raw[1] & ~(stat_wr & reg_wdata[1]));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      dir     <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      scl_oe  <= 1'b0;
      busy    <= 1'b0;
      rx_data <= '0;
      rx_full <= 1'b0;
      tx_data <= '0;
      tx_full <= 1'b0;
    end else begin
      if (rx_rd) rx_full <= 1'b0;
      if (tx_wr) begin
        tx_data <= reg_wdata;
        tx_full <= 1'b1;
      end
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;

      if (start_det) begin
        state  <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WR: begin
            if (scl_rise && bitcnt < CW'(DW)) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == CW'(DW)) begin
              if (state == S_ADDR) begin
                if (shreg[DW-1:1] == own_addr) begin
                  dir    <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end else if (!rx_full) begin
                rx_data <= shreg;
                rx_full <= 1'b1;
                sda_oe  <= 1'b1;
                state   <= S_ACK;
              end else begin
                scl_oe <= 1'b1;
                state  <= S_WAIT_RX;
              end
            end
          end
          S_WAIT_RX: begin
            if (!rx_full) begin
              rx_data <= shreg;
              rx_full <= 1'b1;
              sda_oe  <= 1'b1;
              scl_oe  <= 1'b0;
              state   <= S_ACK;
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              if (!dir) begin
                state <= S_WR;
              end else if (tx_full) begin
                shreg   <= tx_data;
                tx_full <= tx_wr;
                sda_oe  <= ~tx_data[DW-1];
                state   <= S_RD;
              end else begin
                scl_oe <= 1'b1;
                state  <= S_WAIT_TX;
              end
            end
          end
          S_WAIT_TX: begin
            if (tx_full) begin
              shreg   <= tx_data;
              tx_full <= tx_wr;
              sda_oe  <= ~tx_data[DW-1];
              scl_oe  <= 1'b0;
              bitcnt  <= '0;
              state   <= S_RD;
            end
          end
          S_RD: begin
            if (scl_fall) begin
              if (bitcnt == CW'(DW - 1)) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else begin
                sda_oe <= ~shreg[DW-2];
                shreg  <= {shreg[DW-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (!mack) begin
                state <= S_IDLE;
              end else if (tx_full) begin
                shreg   <= tx_data;
                tx_full <= tx_wr;
                sda_oe  <= ~tx_data[DW-1];
                state   <= S_RD;
              end else begin
                scl_oe <= 1'b1;
                state  <= S_WAIT_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end

  always_comb
    case (reg_addr)
      A_OWN:   reg_rdata = {1'b0, own_addr};
      A_RAW:   reg_rdata = {{(DW-3){1'b0}}, busy, raw};
      A_MASK:  reg_rdata = {{(DW-2){1'b0}}, mask};
      A_MSK:   reg_rdata = {{(DW-2){1'b0}}, raw & mask};
      A_RX:    reg_rdata = rx_data;
      A_FLG:   reg_rdata = {{(DW-2){1'b0}}, tx_full, rx_full};
      default: reg_rdata = '0;
    endcase

  p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy && raw[0]);
  p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> !busy && raw[1]);
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[0] && !start_det) |=> !raw[0]);
  p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |-> !irq);
  p_ignore_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe && !scl_oe);
  p_stretch_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_RX) |-> scl_oe);
  p_stretch_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_TX) |-> scl_oe);
  p_sda_low_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && busy) |=> busy && state == S_ADDR);
endmodule

// File: tb/i2c_target_bench.sv
module i2c_target_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic       scl_oe, sda_oe, irq;
  logic       scl_line, sda_line;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;

  assign scl_line = ~(m_scl_lo | scl_oe);
  assign sda_line = ~(m_sda_lo | sda_oe);

  i2c_target u_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  int n_chk = 0, n_fail = 0, max_stretch = 0;
  int exp_q[$];
  int got_val;
  string got_tag;
  event got_ev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input int v);
    exp_q.push_back(v);
  endtask

  task automatic observe(input string tag, input int v);
    got_val = v;
    got_tag = tag;
    ->got_ev;
    #1;
  endtask

  initial forever begin
    @(got_ev);
    if (exp_q.size() == 0) chk(1'b0, got_tag, got_val, -1);
    else begin
      int e;
      e = exp_q.pop_front();
      chk(got_val == e, got_tag, got_val, e);
    end
  end

  task automatic q;
    repeat (10) @(negedge clk);
  endtask

  task automatic scl_rel;
    int n;
    n = 0;
    m_scl_lo = 1'b0;
    while (!scl_line) begin
      @(negedge clk);
      n++;
    end
    if (n > max_stretch) max_stretch = n;
  endtask

  task automatic bus_start;
    m_sda_lo = 1'b1; q; m_scl_lo = 1'b1; q;
  endtask

  task automatic bus_rstart;
    m_sda_lo = 1'b0; q; scl_rel; q; m_sda_lo = 1'b1; q; m_scl_lo = 1'b1; q;
  endtask

  task automatic bus_stop;
    m_sda_lo = 1'b1; q; scl_rel; q; m_sda_lo = 1'b0; q;
  endtask

  task automatic put_bit(input bit b);
    m_sda_lo = !b; q; scl_rel; q; q; m_scl_lo = 1'b1; q;
  endtask

  task automatic get_bit(output bit b);
    m_sda_lo = 1'b0; q; scl_rel; q; b = sda_line; q; m_scl_lo = 1'b1; q;
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(s);
    ack = !s;
  endtask

  task automatic rd_byte(output logic [7:0] v, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!ack);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run;
  end

  localparam logic [6:0] OWN = 7'h3A;

  initial begin
    logic [7:0] d;
    bit ack;
    repeat (5) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    rst_n = 1'b1;
    reg_rd(3'd1, d);
    chk(d == 8'h00, "R1 status", d, 0);

    reg_wr(3'd0, {1'b0, OWN});
    bus_start;
    reg_rd(3'd1, d);
    chk(d == 8'h05, "R2 start flag and busy", d, 8'h05);
    chk(irq == 0, "R4 irq with mask zero", irq, 0);

    wr_byte({OWN, 1'b0}, ack);
    chk(ack, "R5 address ack", ack, 1);
    expect_item(8'hA5);
    wr_byte(8'hA5, ack);
    chk(ack, "R6 data ack", ack, 1);
    reg_rd(3'd5, d); observe("R6 rx byte", d);
    expect_item(8'h3C);
    wr_byte(8'h3C, ack);
    reg_rd(3'd5, d); observe("R6 rx byte", d);
    reg_rd(3'd6, d);
    chk(d[0] == 0, "R6 rx flag cleared by read", d[0], 0);

    expect_item(8'h11);
    expect_item(8'h22);
    wr_byte(8'h11, ack);
    max_stretch = 0;
    fork
      wr_byte(8'h22, ack);
      begin
        logic [7:0] r;
        repeat (600) @(negedge clk);
        chk(scl_line == 0, "R7 clock held while rx full", scl_line, 0);
        reg_rd(3'd5, r); observe("R7 first byte", r);
      end
    join
    chk(max_stretch > 200, "R7 stretch length", max_stretch, 201);
    chk(ack, "R7 ack after release", ack, 1);
    reg_rd(3'd5, d); observe("R7 second byte", d);

    bus_stop;
    reg_rd(3'd1, d);
    chk(d == 8'h03, "R2 stop flag, busy cleared", d, 8'h03);
    reg_wr(3'd2, 8'h01);
    chk(irq == 1, "R4 irq with start masked in", irq, 1);
    reg_rd(3'd3, d);
    chk(d == 8'h01, "R4 masked view", d, 8'h01);
    reg_wr(3'd1, 8'h02);
    reg_rd(3'd1, d);
    chk(d == 8'h01, "R3 clear stop only", d, 8'h01);
    reg_wr(3'd1, 8'h01);
    reg_rd(3'd1, d);
    chk(d == 8'h00, "R3 clear start", d, 0);
    chk(irq == 0, "R4 irq drops after clear", irq, 0);

    bus_start;
    wr_byte({7'h55, 1'b0}, ack);
    chk(!ack, "R5 mismatch no ack", ack, 0);
    wr_byte(8'h00, ack);
    chk(!ack, "R5 ignored after mismatch", ack, 0);
    reg_rd(3'd6, d);
    chk(d[0] == 0, "R5 nothing received", d[0], 0);

    reg_wr(3'd1, 8'h01);
    bus_rstart;
    reg_rd(3'd1, d);
    chk(d == 8'h05, "R10 restart keeps busy, no stop", d, 8'h05);
    wr_byte({OWN, 1'b1}, ack);
    chk(ack, "R10 address matched after restart", ack, 1);

    expect_item(8'hC3);
    expect_item(8'h5A);
    max_stretch = 0;
    fork
      begin
        logic [7:0] v;
        rd_byte(v, 1'b1); observe("R8 tx byte", v);
        rd_byte(v, 1'b0); observe("R8 tx byte", v);
      end
      begin
        repeat (300) @(negedge clk);
        chk(scl_line == 0, "R8 clock held with no tx byte", scl_line, 0);
        reg_wr(3'd4, 8'hC3);
        repeat (30) @(negedge clk);
        reg_wr(3'd4, 8'h5A);
      end
    join
    chk(max_stretch > 200, "R8 stretch length", max_stretch, 201);

    reg_wr(3'd4, 8'h00);
    rd_byte(d, 1'b0);
    chk(d == 8'hFF, "R9 released after nack", d, 8'hFF);
    chk(sda_oe == 0, "R9 data not driven", sda_oe, 0);
    bus_stop;
    reg_rd(3'd1, d);
    chk(d[2] == 0, "R2 busy clear after final stop", d[2], 0);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run;
  end
endmodule